// File: doc/BRIEF.md
# Conditional Debug Breakpoint Match Unit

This block sits beside a processor's retire stage and watches three event streams: retired instruction addresses, data memory accesses (address, data, direction and byte enables), and I/O port accesses. It holds a small set of breakpoint slots. Each slot is loaded through a simple write port with a kind, a match pattern, a per-bit don't-care mask, an inclusive address window, and a data value. When an enabled slot's condition is met, the block raises a one-cycle halt request. With the request it gives the index of the slot that hit and a flag that tells the halt logic whether to stop before the instruction (execute kind) or after it (trap-style data and I/O kinds).

Once a halt request has fired, further requests are held off until the debugger pulses the resume input. Only retired instructions reach the execute comparators, so fetched-but-discarded instructions never cause a hit.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, `halt`, `halt_slot` and `halt_trap` are 0 and every slot is disabled, so no event produces a halt.
- R2: A slot whose enable bit (control bit 0) is 0 never hits, whatever its other settings.
- R3: An address compare ignores every bit position set in the slot's mask, and all other bits must equal the pattern. A pattern of 0x1004 with mask 0x9 (low nibble X10X) matches 0x1005 and 0x100D but not 0x1000 or 0x1009.
- R4: Execute slots (kind 0, control bits 2:1) react only to cycles with `ret_valid` high. An address presented with `ret_valid` low never hits.
- R5: A data read-or-write slot (kind 1) hits on reads and on writes. A data-write slot (kind 2) hits only when `dacc_write` is 1.
- R6: With range mode set (control bit 3) on a data slot, any access address with lo <= address <= hi hits, both bounds included, and the mask is ignored. If lo > hi, nothing hits.
- R7: With the data qualifier set (control bit 4) on a data slot, a hit also needs at least one enabled byte and every byte lane with `dacc_be` set equal to the stored value. Lanes that are not enabled are not compared.
- R8: An I/O slot (kind 3) compares `io_port` against the low bits of its pattern under its mask when `io_valid` is high.
- R9: When several slots hit in one cycle, `halt_slot` reports the lowest index.
- R10: `halt` rises for one cycle, in the cycle after the triggering event. After that, no further halt fires until a cycle with `resume` high has passed.
- R11: `halt_trap` is 0 for an execute hit and 1 for a data or I/O hit. With no halt, `halt_slot` and `halt_trap` are 0.
- R12: A slot responds only to events of its own kind. For example, an execute slot ignores a data or I/O access to its address.
- R13: Configuration writes select a slot with `cfg_slot` and a field with `cfg_field`: 0 control, 1 pattern, 2 mask (1 = don't care), 3 range low, 4 range high, 5 data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | IDX_W | Slot selected for the write |
| cfg_field | input | 3 | Field selected for the write |
| cfg_wdata | input | XLEN | Write data |
| ret_valid | input | 1 | An instruction is retiring |
| ret_addr | input | XLEN | Address of the retiring instruction |
| dacc_valid | input | 1 | A data access completes |
| dacc_addr | input | XLEN | Data access address |
| dacc_data | input | XLEN | Data read or written |
| dacc_write | input | 1 | 1 = write, 0 = read |
| dacc_be | input | XLEN/8 | Byte lanes touched by the access |
| io_valid | input | 1 | An I/O port access completes |
| io_port | input | IO_W | I/O port address |
| resume | input | 1 | Re-arms halt generation |
| halt | output | 1 | One-cycle halt request |
| halt_slot | output | IDX_W | Index of the slot that hit |
| halt_trap | output | 1 | 1 = stop after the instruction, 0 = stop before it |

## Verification
The bench uses the default build: four slots, 32-bit addresses and data, and a 16-bit I/O port. With four slots, every slot index can be programmed with a different kind, so a priority contest among three simultaneous hits (execute on slots 1 and 2, I/O on slot 3) can be set up. The four byte lanes of a 32-bit access allow a partial byte-enable compare, in which a differing byte that is not enabled is ignored. The 16-bit port is wide enough to show that a masked low nibble matches while an upper-bit mismatch does not.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    BK_EXEC = 2'd0,
    BK_DRW  = 2'd1,
    BK_DWR  = 2'd2,
    BK_IO   = 2'd3
  } bk_kind_e;

  typedef struct packed {
    logic     dq;
    logic     rng;
    bk_kind_e kind;
    logic     en;
  } bk_ctrl_t;

  localparam logic [2:0] FLD_CTRL = 3'd0;
  localparam logic [2:0] FLD_PAT  = 3'd1;
  localparam logic [2:0] FLD_MSK  = 3'd2;
  localparam logic [2:0] FLD_LO   = 3'd3;
  localparam logic [2:0] FLD_HI   = 3'd4;
  localparam logic [2:0] FLD_DVAL = 3'd5;

endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [IDX_W-1:0]                 cfg_slot,
  input  logic [2:0]                       cfg_field,
  input  logic [XLEN-1:0]                  cfg_wdata,
  output bk_ctrl_t [NUM_SLOTS-1:0]         ctrl_o,
  output logic [NUM_SLOTS-1:0][XLEN-1:0]   pat_o,
  output logic [NUM_SLOTS-1:0][XLEN-1:0]   msk_o,
  output logic [NUM_SLOTS-1:0][XLEN-1:0]   lo_o,
  output logic [NUM_SLOTS-1:0][XLEN-1:0]   hi_o,
  output logic [NUM_SLOTS-1:0][XLEN-1:0]   dval_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic sel;
    assign sel = cfg_we && (cfg_slot == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_o[s] <= '0;
        pat_o[s]  <= '0;
        msk_o[s]  <= '0;
        lo_o[s]   <= '0;
        hi_o[s]   <= '0;
        dval_o[s] <= '0;
      end else if (sel) begin
        case (cfg_field)
          FLD_CTRL: begin
            ctrl_o[s].en   <= cfg_wdata[0];
            ctrl_o[s].kind <= bk_kind_e'(cfg_wdata[2:1]);
            ctrl_o[s].rng  <= cfg_wdata[3];
            ctrl_o[s].dq   <= cfg_wdata[4];
          end
          FLD_PAT:  pat_o[s]  <= cfg_wdata;
          FLD_MSK:  msk_o[s]  <= cfg_wdata;
          FLD_LO:   lo_o[s]   <= cfg_wdata;
          FLD_HI:   hi_o[s]   <= cfg_wdata;
          FLD_DVAL: dval_o[s] <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
  import bkpt_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IO_W = 16,
  localparam int BE_W = XLEN / 8
) (
  input  bk_ctrl_t          ctrl,
  input  logic [XLEN-1:0]   pat,
  input  logic [XLEN-1:0]   msk,
  input  logic [XLEN-1:0]   lo,
  input  logic [XLEN-1:0]   hi,
  input  logic [XLEN-1:0]   dval,
  input  logic              ret_valid,
  input  logic [XLEN-1:0]   ret_addr,
  input  logic              dacc_valid,
  input  logic [XLEN-1:0]   dacc_addr,
  input  logic [XLEN-1:0]   dacc_data,
  input  logic              dacc_write,
  input  logic [BE_W-1:0]   dacc_be,
  input  logic              io_valid,
  input  logic [IO_W-1:0]   io_port,
  output logic              hit
);

  logic            exec_am;
  logic            data_am;
  logic            io_am;
  logic            in_rng;
  logic            addr_ok;
  logic            dq_ok;
  logic [BE_W-1:0] lane_ok;

  // masked equality: a set mask bit removes that position from the compare
  assign exec_am = ((ret_addr ^ pat) & ~msk) == '0;
  assign data_am = ((dacc_addr ^ pat) & ~msk) == '0;
  assign io_am   = ((io_port ^ pat[IO_W-1:0]) & ~msk[IO_W-1:0]) == '0;

  // inclusive window; an inverted window never matches
  assign in_rng  = (lo <= hi) && (dacc_addr >= lo) && (dacc_addr <= hi);
  assign addr_ok = ctrl.rng ? in_rng : data_am;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_ok[b] = !dacc_be[b] || (dacc_data[8*b +: 8] == dval[8*b +: 8]);
  end

  assign dq_ok = !ctrl.dq || ((&lane_ok) && (|dacc_be));

  always_comb begin
    hit = 1'b0;
    if (ctrl.en) begin
      case (ctrl.kind)
        BK_EXEC: hit = ret_valid && exec_am;
        BK_DRW:  hit = dacc_valid && addr_ok && dq_ok;
        BK_DWR:  hit = dacc_valid && dacc_write && addr_ok && dq_ok;
        BK_IO:   hit = io_valid && io_am;
        default: hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bkpt_pick.sv
module bkpt_pick
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_SLOTS-1:0]     hits,
  input  bk_ctrl_t [NUM_SLOTS-1:0] ctrl,
  output logic                     any,
  output logic [IDX_W-1:0]         idx,
  output logic                     trap
);

  always_comb begin
    any  = |hits;
    idx  = '0;
    trap = 1'b0;
    // walk downward so the lowest hitting index is the last one written
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        idx  = IDX_W'(i);
        trap = (ctrl[i].kind != BK_EXEC);
      end
    end
  end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int XLEN      = 32,
  parameter int IO_W      = 16,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BE_W     = XLEN / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_slot,
  input  logic [2:0]        cfg_field,
  input  logic [XLEN-1:0]   cfg_wdata,
  input  logic              ret_valid,
  input  logic [XLEN-1:0]   ret_addr,
  input  logic              dacc_valid,
  input  logic [XLEN-1:0]   dacc_addr,
  input  logic [XLEN-1:0]   dacc_data,
  input  logic              dacc_write,
  input  logic [BE_W-1:0]   dacc_be,
  input  logic              io_valid,
  input  logic [IO_W-1:0]   io_port,
  input  logic              resume,
  output logic              halt,
  output logic [IDX_W-1:0]  halt_slot,
  output logic              halt_trap
);

  bk_ctrl_t [NUM_SLOTS-1:0]       ctrl;
  logic [NUM_SLOTS-1:0][XLEN-1:0] pat;
  logic [NUM_SLOTS-1:0][XLEN-1:0] msk;
  logic [NUM_SLOTS-1:0][XLEN-1:0] lo;
  logic [NUM_SLOTS-1:0][XLEN-1:0] hi;
  logic [NUM_SLOTS-1:0][XLEN-1:0] dval;
  logic [NUM_SLOTS-1:0]           hits;
  logic                           any_hit;
  logic [IDX_W-1:0]               win_idx;
  logic                           win_trap;
  logic                           armed;
  logic                           fire;

  bkpt_cfg_regs #(
    .NUM_SLOTS (NUM_SLOTS),
    .XLEN      (XLEN),
    .IDX_W     (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_slot  (cfg_slot),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .ctrl_o    (ctrl),
    .pat_o     (pat),
    .msk_o     (msk),
    .lo_o      (lo),
    .hi_o      (hi),
    .dval_o    (dval)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    bkpt_slot_cmp #(
      .XLEN (XLEN),
      .IO_W (IO_W)
    ) u_cmp (
      .ctrl       (ctrl[s]),
      .pat        (pat[s]),
      .msk        (msk[s]),
      .lo         (lo[s]),
      .hi         (hi[s]),
      .dval       (dval[s]),
      .ret_valid  (ret_valid),
      .ret_addr   (ret_addr),
      .dacc_valid (dacc_valid),
      .dacc_addr  (dacc_addr),
      .dacc_data  (dacc_data),
      .dacc_write (dacc_write),
      .dacc_be    (dacc_be),
      .io_valid   (io_valid),
      .io_port    (io_port),
      .hit        (hits[s])
    );
  end

  bkpt_pick #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_pick (
    .hits (hits),
    .ctrl (ctrl),
    .any  (any_hit),
    .idx  (win_idx),
    .trap (win_trap)
  );

  assign fire = armed && any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b1;
      halt      <= 1'b0;
      halt_slot <= '0;
      halt_trap <= 1'b0;
    end else begin
      halt      <= fire;
      halt_slot <= fire ? win_idx : '0;
      halt_trap <= fire && win_trap;
      if (fire)        armed <= 1'b0;
      else if (resume) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ret_valid,
  input logic             dacc_valid,
  input logic             io_valid,
  input logic             halt,
  input logic [IDX_W-1:0] halt_slot,
  input logic             halt_trap
);

  // R1: reset drives the request low on the following cycle
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !halt);

  // R10: a request lasts exactly one cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    halt |=> !halt);

  // R11: execute-style request needs a retiring instruction the cycle before
  a_r11_exec_source: assert property (@(posedge clk) disable iff (rst)
    (halt && !halt_trap) |-> $past(ret_valid));

  // R11: trap-style request needs a data or I/O access the cycle before
  a_r11_trap_source: assert property (@(posedge clk) disable iff (rst)
    (halt && halt_trap) |-> $past(dacc_valid || io_valid));

  // R11: side outputs are quiet without a request
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !halt |-> (halt_slot == '0 && !halt_trap));

endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ret_valid  (ret_valid),
  .dacc_valid (dacc_valid),
  .io_valid   (io_valid),
  .halt       (halt),
  .halt_slot  (halt_slot),
  .halt_trap  (halt_trap)
);

// File: tb/bkpt_match_unit_test.sv
`timescale 1ns/1ps
module bkpt_match_unit_test;

  localparam int NS = 4;
  localparam int XL = 32;
  localparam int IW = 16;
  localparam int IX = 2;
  localparam int BW = XL / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IX-1:0] cfg_slot = '0;
  logic [2:0]    cfg_field = '0;
  logic [XL-1:0] cfg_wdata = '0;
  logic          ret_valid = 1'b0;
  logic [XL-1:0] ret_addr = '0;
  logic          dacc_valid = 1'b0;
  logic [XL-1:0] dacc_addr = '0;
  logic [XL-1:0] dacc_data = '0;
  logic          dacc_write = 1'b0;
  logic [BW-1:0] dacc_be = '0;
  logic          io_valid = 1'b0;
  logic [IW-1:0] io_port = '0;
  logic          resume = 1'b0;
  logic          halt;
  logic [IX-1:0] halt_slot;
  logic          halt_trap;

  bkpt_match_unit #(.NUM_SLOTS(NS), .XLEN(XL), .IO_W(IW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .ret_valid(ret_valid),
    .ret_addr(ret_addr), .dacc_valid(dacc_valid), .dacc_addr(dacc_addr),
    .dacc_data(dacc_data), .dacc_write(dacc_write), .dacc_be(dacc_be),
    .io_valid(io_valid), .io_port(io_port), .resume(resume),
    .halt(halt), .halt_slot(halt_slot), .halt_trap(halt_trap)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic  h;
    int    s;
    logic  t;
    int    due;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each expected item in the cycle its result is due
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      n_chk++;
      if (halt !== e.h || halt_slot !== IX'(e.s) || halt_trap !== e.t) begin
        n_err++;
        $display("FAIL %s: got halt=%0b slot=%0d trap=%0b, expected halt=%0b slot=%0d trap=%0b",
                 e.tag, halt, halt_slot, halt_trap, e.h, e.s, e.t);
      end
    end
  end

  task automatic clear_ev();
    cfg_we = 0; resume = 0; ret_valid = 0; dacc_valid = 0; io_valid = 0;
  endtask

  task automatic push(input logic h, input int s, input logic t, input string tag);
    exp_t e;
    e.h = h; e.s = s; e.t = t; e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic rv, input logic [XL-1:0] ra,
                      input logic dv, input logic [XL-1:0] da,
                      input logic [XL-1:0] dd, input logic dw,
                      input logic [BW-1:0] dbe, input logic iv,
                      input logic [IW-1:0] ip, input logic h,
                      input int s, input logic t, input string tag);
    @(negedge clk);
    clear_ev();
    ret_valid = rv; ret_addr = ra;
    dacc_valid = dv; dacc_addr = da; dacc_data = dd; dacc_write = dw; dacc_be = dbe;
    io_valid = iv; io_port = ip;
    push(h, s, t, tag);
  endtask

  task automatic ex(input logic [XL-1:0] a, input logic v, input logic h,
                    input int s, input logic t, input string tag);
    step(v, a, 0, '0, '0, 0, '0, 0, '0, h, s, t, tag);
  endtask

  task automatic da(input logic [XL-1:0] a, input logic [XL-1:0] d, input logic w,
                    input logic [BW-1:0] be, input logic h, input int s,
                    input logic t, input string tag);
    step(0, '0, 1, a, d, w, be, 0, '0, h, s, t, tag);
  endtask

  task automatic iop(input logic [IW-1:0] p, input logic h, input int s,
                     input logic t, input string tag);
    step(0, '0, 0, '0, '0, 0, '0, 1, p, h, s, t, tag);
  endtask

  task automatic cfg(input int slot, input logic [2:0] fld, input logic [XL-1:0] v);
    @(negedge clk);
    clear_ev();
    cfg_we = 1; cfg_slot = IX'(slot); cfg_field = fld; cfg_wdata = v;
    push(0, 0, 0, "R13 cfg cycle");
  endtask

  task automatic rsm();
    @(negedge clk);
    clear_ev();
    resume = 1;
    push(0, 0, 0, "R10 resume cycle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    n_chk++;
    if (halt !== 0 || halt_slot !== '0 || halt_trap !== 0) begin
      n_err++;
      $display("FAIL R1: got halt=%0b slot=%0d trap=%0b, expected 0 0 0", halt, halt_slot, halt_trap);
    end
    // R1 R2: reset leaves every slot disabled
    ex(32'h0, 1, 0, 0, 0, "R1 disabled after reset");
    da(32'h0, 32'h0, 1, 4'hF, 0, 0, 0, "R1 data after reset");

    // R3: X10X low-nibble mask on an execute slot
    cfg(0, 3'd1, 32'h1004);
    cfg(0, 3'd2, 32'h9);
    cfg(0, 3'd0, 32'h01);
    ex(32'h1000, 1, 0, 0, 0, "R3 0x1000 miss");
    ex(32'h1009, 1, 0, 0, 0, "R3 0x1009 miss");
    ex(32'h1005, 1, 1, 0, 0, "R3 0x1005 hit");
    rsm();
    ex(32'h100D, 1, 1, 0, 0, "R3 0x100D hit");
    rsm();
    ex(32'h1005, 0, 0, 0, 0, "R4 not retired");
    da(32'h1005, 32'h0, 1, 4'hF, 0, 0, 0, "R12 data ignored by exec slot");
    iop(16'h1005, 0, 0, 0, "R12 io ignored by exec slot");
    cfg(0, 3'd0, 32'h00);
    ex(32'h1005, 1, 0, 0, 0, "R2 disabled slot");

    // R6 R5: data-write range slot, mask all don't-care
    cfg(1, 3'd1, 32'h0);
    cfg(1, 3'd2, 32'hFFFF_FFFF);
    cfg(1, 3'd3, 32'h1100);
    cfg(1, 3'd4, 32'h1200);
    cfg(1, 3'd0, 32'h0D);
    da(32'h10FF, 32'h0, 1, 4'hF, 0, 0, 0, "R6 below window");
    da(32'h1100, 32'h0, 1, 4'hF, 1, 1, 1, "R6 low bound");
    rsm();
    da(32'h1200, 32'h0, 1, 4'hF, 1, 1, 1, "R6 high bound");
    rsm();
    da(32'h1201, 32'h0, 1, 4'hF, 0, 0, 0, "R6 above window, mask ignored");
    da(32'h1150, 32'h0, 0, 4'hF, 0, 0, 0, "R5 read on write-only slot");
    da(32'h1150, 32'h0, 1, 4'hF, 1, 1, 1, "R5 write on write-only slot");
    rsm();
    cfg(1, 3'd3, 32'h1300);
    da(32'h1250, 32'h0, 1, 4'hF, 0, 0, 0, "R6 inverted window");
    da(32'h1300, 32'h0, 1, 4'hF, 0, 0, 0, "R6 inverted window at lo");
    cfg(1, 3'd0, 32'h00);

    // R7 R5: data read-or-write slot with value qualifier
    cfg(2, 3'd1, 32'h2000);
    cfg(2, 3'd2, 32'h0);
    cfg(2, 3'd5, 32'h1122_3355);
    cfg(2, 3'd0, 32'h13);
    da(32'h2000, 32'h1122_3355, 0, 4'hF, 1, 2, 1, "R7 read value match");
    rsm();
    da(32'h2000, 32'hAA22_3355, 1, 4'h7, 1, 2, 1, "R7 unenabled lane ignored");
    rsm();
    da(32'h2000, 32'h1122_3356, 1, 4'h1, 0, 0, 0, "R7 lane mismatch");
    da(32'h2000, 32'h1122_3355, 1, 4'h0, 0, 0, 0, "R7 no lanes");
    da(32'h2004, 32'h1122_3355, 1, 4'hF, 0, 0, 0, "R7 address mismatch");
    cfg(2, 3'd0, 32'h03);
    da(32'h2000, 32'hDEAD_BEEF, 0, 4'hF, 1, 2, 1, "R5 read without qualifier");
    rsm();
    cfg(2, 3'd0, 32'h00);

    // R8: I/O slot with masked low nibble
    cfg(3, 3'd1, 32'h80);
    cfg(3, 3'd2, 32'h0F);
    cfg(3, 3'd0, 32'h07);
    iop(16'h008C, 1, 3, 1, "R8 io hit");
    rsm();
    iop(16'h0090, 0, 0, 0, "R8 io miss");
    ex(32'h80, 1, 0, 0, 0, "R12 exec ignored by io slot");

    // R9 R11: simultaneous hits
    cfg(1, 3'd1, 32'h3000);
    cfg(1, 3'd2, 32'h0);
    cfg(1, 3'd0, 32'h01);
    cfg(2, 3'd1, 32'h3000);
    cfg(2, 3'd2, 32'h0);
    cfg(2, 3'd0, 32'h01);
    step(1, 32'h3000, 0, '0, '0, 0, '0, 1, 16'h0085, 1, 1, 0, "R9 lowest of 1,2,3");
    rsm();
    cfg(1, 3'd0, 32'h00);
    step(1, 32'h3000, 0, '0, '0, 0, '0, 1, 16'h0085, 1, 2, 0, "R9 lowest of 2,3");
    rsm();
    cfg(2, 3'd0, 32'h00);
    step(1, 32'h3000, 0, '0, '0, 0, '0, 1, 16'h0085, 1, 3, 1, "R11 io wins alone");
    rsm();

    // R10: single pulse and block until resume
    cfg(3, 3'd0, 32'h00);
    cfg(2, 3'd0, 32'h01);
    ex(32'h3000, 1, 1, 2, 0, "R10 first hit");
    ex(32'h3000, 1, 0, 0, 0, "R10 blocked");
    ex(32'h3000, 1, 0, 0, 0, "R10 still blocked");
    rsm();
    ex(32'h3000, 1, 1, 2, 0, "R10 re-armed hit");
    rsm();

    repeat (3) begin
      @(negedge clk);
      clear_ev();
    end
    while (q.size() > 0) @(negedge clk);
    finish_run();
  end

endmodule